// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and the calendar date in seven packed-BCD registers: seconds, minutes, hours, date, month, weekday and a two-digit year. An external prescaler supplies a one-cycle enable pulse once per second. On each pulse the seconds step forward, and carries ripple through minutes, hours, date, month and year. The day-of-week counter advances together with the date. Month ends follow the calendar. February has 29 days when the two-digit year is a multiple of four, which is correct for the years 2000 to 2099.

The hour register has two layouts. In 24-hour mode it counts 00 to 23. In 12-hour mode it counts 12, 01 … 11 and carries a PM flag. A halt flag held in the seconds register freezes the whole counter. A host loads any single field through a select/data write port, and all seven registers appear in parallel at the outputs for snapshot or readback. The host must load valid BCD values and a date that exists in the loaded month.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the registers read seconds 0x80 (halted, 00 s), minutes 0x00, hours 0x00 (24-hour mode), date 0x01, month 0x01, weekday 0x01 and year 0x00.
- R2: With the halt flag clear, each tick advances seconds 00→59 in BCD. The step from 59 returns seconds to 00 and advances minutes, which count 00→59 the same way.
- R3: In 24-hour mode (hours bit 7 = 0) the hour counts 00→23 in BCD using bits 5:0. The step from 23 returns it to 00 and advances the day.
- R4: In 12-hour mode (hours bit 7 = 1) bits 4:0 hold the BCD hour in the order 12, 01 … 11, and bit 5 is the PM flag (1 = PM). Going from 11 to 12 toggles PM, and the day advances only on the step from 11 PM to 12 AM. The mode bit never changes except by a host write.
- R5: When the day advances from the last day of its month, the date returns to 01 and the month advances. April, June, September and November end at 30. January, March, May, July, August, October and December end at 31.
- R6: February ends at 29 when the BCD year is divisible by four, and at 28 otherwise.
- R7: A month advance from 12 returns the month to 01 and advances the year. The year wraps from 99 to 00.
- R8: The weekday counts 1→7 and wraps to 1, advancing exactly when the date advances.
- R9: While seconds bit 7 (halt) is 1, ticks change no register. Writing seconds with bit 7 = 0 lets counting resume on the next tick.
- R10: A write with select 0..6 loads seconds, minutes, hours, date, month, weekday or year in that order. Stored bits are limited to seconds [7:0], minutes [6:0], hours bits 7 and 5:0, date [5:0], month [4:0], weekday [2:0] and year [7:0]; unused bits read 0. Select 7 changes nothing. A tick arriving in a write cycle is discarded.
- R11: With no tick and no write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second enable, one clock wide |
| wr_en_i | input | 1 | Host field write strobe |
| wr_sel_i | input | 3 | Field select: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 weekday, 6 year |
| wr_data_i | input | 8 | BCD data for the selected field |
| sec_o | output | 8 | Halt flag (bit 7) and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Mode bit, PM or tens bit, BCD hour |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| wday_o | output | 8 | Weekday 1 to 7 |
| year_o | output | 8 | BCD two-digit year |

## Verification
Several properties are checked on every cycle. Each field stays in its legal BCD range. The hour layout bit survives ticks. A halted or idle counter holds every register. A seconds write lands exactly one cycle later. Other behaviour only the bench scenarios can show, because each depends on a particular starting value: the month-end table, leap and non-leap February, the December-to-January year carry with the 99 wrap, the 11-to-12 PM toggle and the day carry from 11 PM. The same holds for the discarded tick in a write cycle and the bit masking on writes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] wday;
        logic [7:0] year;
    } rtc_regs_t;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_DATE = 3'd3,
        FLD_MON  = 3'd4,
        FLD_WDAY = 3'd5,
        FLD_YEAR = 3'd6,
        FLD_NONE = 3'd7
    } rtc_field_e;

    localparam logic [7:0] MASK_SEC  = 8'hFF;
    localparam logic [7:0] MASK_MIN  = 8'h7F;
    localparam logic [7:0] MASK_HOUR = 8'hBF;
    localparam logic [7:0] MASK_DATE = 8'h3F;
    localparam logic [7:0] MASK_MON  = 8'h1F;
    localparam logic [7:0] MASK_WDAY = 8'h07;
    localparam logic [7:0] MASK_YEAR = 8'hFF;

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output logic [W-1:0] nxt_o,
    output logic         wrap_o
);
    logic [DIGITS-1:0] cy;
    logic [W-1:0]      inc;

    assign cy[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] dig;
        assign dig = val_i[4*g +: 4];
        assign inc[4*g +: 4] = cy[g] ? ((dig == 4'd9) ? 4'd0 : dig + 4'd1) : dig;
        if (g < DIGITS - 1) begin : g_cy
            assign cy[g+1] = cy[g] & (dig == 4'd9);
        end
    end

    assign wrap_o = (val_i == hi_i);
    assign nxt_o  = wrap_o ? lo_i : inc;
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
    input  logic [7:0] hour_i,
    output logic [7:0] hour_o,
    output logic       day_o
);
    logic       mode12;
    logic [7:0] val;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [7:0] nxt;
    logic       wrap;
    logic       at_eleven;
    logic       pm_n;

    assign mode12    = hour_i[7];
    assign val       = mode12 ? {3'b000, hour_i[4:0]} : {1'b0, hour_i[6:0]};
    assign lo        = mode12 ? 8'h01 : 8'h00;
    assign hi        = mode12 ? 8'h12 : 8'h23;
    assign at_eleven = (hour_i[4:0] == 5'h11);

    rtc_bcd_step #(.DIGITS(2)) u_step (
        .val_i  (val),
        .lo_i   (lo),
        .hi_i   (hi),
        .nxt_o  (nxt),
        .wrap_o (wrap)
    );

    always_comb begin
        pm_n = hour_i[5] ^ at_eleven;
        if (mode12) begin
            hour_o = {1'b1, nxt[6], pm_n, nxt[4:0]};
            day_o  = at_eleven & hour_i[5];
        end else begin
            hour_o = nxt;
            day_o  = wrap;
        end
    end
endmodule

// File: rtl/rtc_month_end.sv
module rtc_month_end (
    input  logic [7:0] mon_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_o
);
    logic leap;

    assign leap = ((({4'd0, year_i[7:4]} * 8'd10) + {4'd0, year_i[3:0]}) % 8'd4) == 8'd0;

    always_comb begin
        case (mon_i)
            8'h02:                      last_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
            default:                    last_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core #(
    parameter logic       RST_HALT = 1'b1,
    parameter logic [7:0] RST_YEAR = 8'h00,
    parameter logic [7:0] RST_WDAY = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] wday_o,
    output logic [7:0] year_o
);
    import rtc_pkg::*;

    localparam rtc_regs_t RST_REGS = '{
        sec:  {RST_HALT, 7'h00},
        min:  8'h00,
        hour: 8'h00,
        date: 8'h01,
        mon:  8'h01,
        wday: RST_WDAY,
        year: RST_YEAR
    };

    rtc_regs_t st_d, st_q;

    logic [7:0] sec_nxt, min_nxt, hour_nxt, date_nxt, mon_nxt, wday_nxt, year_nxt;
    logic       sec_wrap, min_wrap, day_cy, date_wrap, mon_wrap;
    logic       wday_wrap_unused, year_wrap_unused;
    logic [7:0] last_day;
    logic       adv_d;

    rtc_bcd_step #(.DIGITS(2)) u_sec (
        .val_i ({1'b0, st_q.sec[6:0]}), .lo_i (8'h00), .hi_i (8'h59),
        .nxt_o (sec_nxt), .wrap_o (sec_wrap)
    );
    rtc_bcd_step #(.DIGITS(2)) u_min (
        .val_i (st_q.min), .lo_i (8'h00), .hi_i (8'h59),
        .nxt_o (min_nxt), .wrap_o (min_wrap)
    );
    rtc_hour_step u_hour (
        .hour_i (st_q.hour), .hour_o (hour_nxt), .day_o (day_cy)
    );
    rtc_month_end u_mend (
        .mon_i (st_q.mon), .year_i (st_q.year), .last_o (last_day)
    );
    rtc_bcd_step #(.DIGITS(2)) u_date (
        .val_i (st_q.date), .lo_i (8'h01), .hi_i (last_day),
        .nxt_o (date_nxt), .wrap_o (date_wrap)
    );
    rtc_bcd_step #(.DIGITS(2)) u_mon (
        .val_i (st_q.mon), .lo_i (8'h01), .hi_i (8'h12),
        .nxt_o (mon_nxt), .wrap_o (mon_wrap)
    );
    rtc_bcd_step #(.DIGITS(2)) u_wday (
        .val_i (st_q.wday), .lo_i (8'h01), .hi_i (8'h07),
        .nxt_o (wday_nxt), .wrap_o (wday_wrap_unused)
    );
    rtc_bcd_step #(.DIGITS(2)) u_year (
        .val_i (st_q.year), .lo_i (8'h00), .hi_i (8'h99),
        .nxt_o (year_nxt), .wrap_o (year_wrap_unused)
    );

    always_comb begin
        st_d  = st_q;
        adv_d = tick_i & ~st_q.sec[7] & ~wr_en_i;

        if (adv_d) begin
            st_d.sec = sec_nxt;
            if (sec_wrap) begin
                st_d.min = min_nxt;
                if (min_wrap) begin
                    st_d.hour = hour_nxt;
                    if (day_cy) begin
                        st_d.date = date_nxt;
                        st_d.wday = wday_nxt;
                        if (date_wrap) begin
                            st_d.mon = mon_nxt;
                            if (mon_wrap) begin
                                st_d.year = year_nxt;
                            end
                        end
                    end
                end
            end
        end

        if (wr_en_i) begin
            case (rtc_field_e'(wr_sel_i))
                FLD_SEC:  st_d.sec  = wr_data_i & MASK_SEC;
                FLD_MIN:  st_d.min  = wr_data_i & MASK_MIN;
                FLD_HOUR: st_d.hour = wr_data_i & MASK_HOUR;
                FLD_DATE: st_d.date = wr_data_i & MASK_DATE;
                FLD_MON:  st_d.mon  = wr_data_i & MASK_MON;
                FLD_WDAY: st_d.wday = wr_data_i & MASK_WDAY;
                FLD_YEAR: st_d.year = wr_data_i & MASK_YEAR;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_REGS;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o   = st_q.sec;
    assign min_o   = st_q.min;
    assign hour_o  = st_q.hour;
    assign date_o  = st_q.date;
    assign month_o = st_q.mon;
    assign wday_o  = st_q.wday;
    assign year_o  = st_q.year;
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [2:0] wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] wday_o,
    input logic [7:0] year_o
);
    logic [55:0] all_regs;
    assign all_regs = {sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o};

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[6:4] <= 3'd5) && (sec_o[3:0] <= 4'd9)); // R2

    AST_MIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (min_o[7:4] <= 4'd5) && (min_o[3:0] <= 4'd9)); // R2

    AST_HOUR24_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !hour_o[7] |-> (hour_o[6:0] <= 7'h23) && (hour_o[3:0] <= 4'd9)); // R3

    AST_HOUR12_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hour_o[7] |-> (hour_o[4:0] >= 5'h01) && (hour_o[4:0] <= 5'h12) && !hour_o[6]); // R4

    AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == 3'd2) |=> hour_o[7] == $past(hour_o[7])); // R4

    AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (date_o >= 8'h01) && (date_o <= 8'h31) && (date_o[3:0] <= 4'd9)); // R5

    AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (month_o >= 8'h01) && (month_o <= 8'h12)); // R7

    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wday_o >= 8'h01) && (wday_o <= 8'h07)); // R8

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[7] && !wr_en_i) |=> $stable(all_regs)); // R9

    AST_SEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 3'd0) |=> sec_o == $past(wr_data_i)); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable(all_regs)); // R11
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (.*);

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_sel_i = 3'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o;

    int vectors = 0;
    int fails = 0;

    int m_halt, m_sec, m_min, m_h24, m_h12, m_date, m_mon, m_wday, m_year;

    always #4 clk = ~clk;

    rtc_bcd_core u_rtc_bcd_core (
        .clk, .rst_n, .tick_i, .wr_en_i, .wr_sel_i, .wr_data_i,
        .sec_o, .min_o, .hour_o, .date_o, .month_o, .wday_o, .year_o
    );

    function automatic int bcd2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int mdays(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_hour();
        int h;
        if (m_h12 == 0) return i2bcd(m_h24);
        h = m_h24 % 12;
        if (h == 0) h = 12;
        return 8'h80 | ((m_h24 >= 12) ? 8'h20 : 8'h00) | i2bcd(h);
    endfunction

    task automatic model_tick();
        if (m_halt != 0) return;
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_h24++;
        if (m_h24 < 24) return;
        m_h24 = 0;
        m_wday = (m_wday == 7) ? 1 : m_wday + 1;
        if (m_date == mdays(m_mon, m_year)) begin
            m_date = 1;
            m_mon++;
            if (m_mon == 13) begin
                m_mon = 1;
                m_year = (m_year + 1) % 100;
            end
        end else begin
            m_date++;
        end
    endtask

    task automatic model_write(input logic [2:0] sel, input logic [7:0] d);
        int h;
        case (sel)
            3'd0: begin m_halt = int'(d[7]); m_sec = bcd2i({1'b0, d[6:0]}); end
            3'd1: m_min = bcd2i({1'b0, d[6:0]});
            3'd2: begin
                m_h12 = int'(d[7]);
                if (d[7]) begin
                    h = bcd2i({3'b0, d[4:0]});
                    m_h24 = (h == 12 ? 0 : h) + (d[5] ? 12 : 0);
                end else begin
                    m_h24 = bcd2i({2'b0, d[5:0]});
                end
            end
            3'd3: m_date = bcd2i({2'b0, d[5:0]});
            3'd4: m_mon  = bcd2i({3'b0, d[4:0]});
            3'd5: m_wday = int'(d[2:0]);
            3'd6: m_year = bcd2i(d);
            default: ;
        endcase
    endtask

    task automatic check_all(input string req);
        logic [55:0] act, exp;
        act = {sec_o, min_o, hour_o, date_o, month_o, wday_o, year_o};
        exp = {8'(m_halt) << 7 | i2bcd(m_sec), i2bcd(m_min), exp_hour(),
               i2bcd(m_date), i2bcd(m_mon), 8'(m_wday), i2bcd(m_year)};
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h (sec min hour date mon wday year)", req, act, exp);
        end
    endtask

    task automatic op(input bit tk, input bit we, input logic [2:0] sel,
                      input logic [7:0] d, input string req);
        @(negedge clk);
        tick_i = tk; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
        if (we) model_write(sel, d);
        else if (tk) model_tick();
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        check_all(req);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d, input string req);
        op(1'b0, 1'b1, sel, d, req);
    endtask

    task automatic tk(input string req);
        op(1'b1, 1'b0, 3'd0, 8'd0, req);
    endtask

    task automatic set_eod(input logic [7:0] hr, input logic [7:0] dt,
                           input logic [7:0] mo, input logic [7:0] yr, input string req);
        wr(3'd6, yr, req); wr(3'd4, mo, req); wr(3'd3, dt, req);
        wr(3'd2, hr, req); wr(3'd1, 8'h59, req); wr(3'd0, 8'h59, req);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        m_halt = 1; m_sec = 0; m_min = 0; m_h24 = 0; m_h12 = 0;
        m_date = 1; m_mon = 1; m_wday = 1; m_year = 0;
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset state");

        tk("R9 tick while halted from reset");
        wr(3'd0, 8'h00, "R9 clear halt");
        tk("R2 first second");
        wr(3'd1, 8'h09, "R2"); wr(3'd0, 8'h59, "R2");
        tk("R2 minute carry");

        wr(3'd5, 8'h07, "R8");
        set_eod(8'h23, 8'h28, 8'h02, 8'h24, "R6");
        tk("R6 leap Feb 28 to 29, R8 weekday 7 to 1");
        set_eod(8'h23, 8'h29, 8'h02, 8'h24, "R6");
        tk("R6 leap Feb 29 to Mar 1");
        set_eod(8'h23, 8'h28, 8'h02, 8'h23, "R6");
        tk("R6 non-leap Feb 28 to Mar 1");
        set_eod(8'h23, 8'h28, 8'h02, 8'h00, "R6");
        tk("R6 year 00 is leap");
        set_eod(8'h23, 8'h30, 8'h04, 8'h15, "R5");
        tk("R5 Apr 30 to May 1");
        set_eod(8'h23, 8'h30, 8'h09, 8'h15, "R5");
        tk("R5 Sep 30 to Oct 1");
        set_eod(8'h23, 8'h30, 8'h01, 8'h15, "R5");
        tk("R5 Jan 30 to Jan 31");
        set_eod(8'h23, 8'h31, 8'h07, 8'h15, "R5");
        tk("R5 Jul 31 to Aug 1");
        set_eod(8'h23, 8'h31, 8'h12, 8'h99, "R7");
        tk("R7 Dec 31 99 to Jan 1 00");
        set_eod(8'h23, 8'h31, 8'h12, 8'h09, "R7");
        tk("R7 year BCD carry 09 to 10");

        set_eod(8'h09, 8'h05, 8'h03, 8'h15, "R3");
        tk("R3 hour 09 to 10");
        set_eod(8'h19, 8'h05, 8'h03, 8'h15, "R3");
        tk("R3 hour 19 to 20");

        set_eod(8'h91, 8'h05, 8'h03, 8'h15, "R4");
        tk("R4 11 AM to 12 PM, PM toggles, no day");
        wr(3'd1, 8'h59, "R4"); wr(3'd0, 8'h59, "R4");
        tk("R4 12 PM to 01 PM");
        set_eod(8'hB1, 8'h05, 8'h03, 8'h15, "R4");
        tk("R4 11 PM to 12 AM advances day");
        wr(3'd1, 8'h59, "R4"); wr(3'd0, 8'h59, "R4");
        tk("R4 12 AM to 01 AM");

        wr(3'd0, 8'h85, "R9 set halt");
        tk("R9 halted tick 1"); tk("R9 halted tick 2"); tk("R9 halted tick 3");
        wr(3'd0, 8'h05, "R9 release halt");
        tk("R9 resumed");

        op(1'b1, 1'b1, 3'd1, 8'h33, "R10 tick discarded in write cycle");
        op(1'b1, 1'b1, 3'd7, 8'hFF, "R10 select 7 ignored, tick discarded");
        wr(3'd1, 8'hD5, "R10 minute bit 7 masked");
        wr(3'd2, 8'h63, "R10 hour bit 6 masked");
        wr(3'd5, 8'hF3, "R10 weekday masked");
        wr(3'd3, 8'hD2, "R10 date masked");
        wr(3'd4, 8'hE1, "R10 month masked");

        repeat (3) op(1'b0, 1'b0, 3'd0, 8'h00, "R11 idle hold");

        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 55) begin
                tk("R2 random tick");
            end else if (r < 90) begin
                logic [2:0] sel;
                logic [7:0] d;
                bit both;
                both = (r < 62);
                sel = 3'($urandom_range(0, 7));
                case (sel)
                    3'd0: d = (($urandom_range(0, 7) == 0) ? 8'h80 : 8'h00)
                              | i2bcd(($urandom_range(0, 1) == 1) ? int'($urandom_range(55, 59))
                                                                  : int'($urandom_range(0, 59)));
                    3'd1: d = i2bcd(($urandom_range(0, 1) == 1) ? int'($urandom_range(58, 59))
                                                                : int'($urandom_range(0, 59)));
                    3'd2: begin
                        if ($urandom_range(0, 1) == 1)
                            d = 8'h80 | (($urandom_range(0, 1) == 1) ? 8'h20 : 8'h00)
                                | i2bcd(int'($urandom_range(1, 12)));
                        else
                            d = i2bcd(($urandom_range(0, 1) == 1) ? 23 : int'($urandom_range(0, 23)));
                    end
                    3'd3: d = i2bcd(int'($urandom_range(1, 28)));
                    3'd4: begin
                        if (m_date > 28) sel = 3'd7;
                        d = i2bcd(int'($urandom_range(1, 12)));
                    end
                    3'd5: d = 8'($urandom_range(1, 7));
                    3'd6: begin
                        if (m_mon == 2 && m_date == 29) sel = 3'd7;
                        d = i2bcd(int'($urandom_range(0, 99)));
                    end
                    default: d = 8'($urandom_range(0, 255));
                endcase
                op(both, 1'b1, sel, d, "R10 random write");
            end else begin
                op(1'b0, 1'b0, 3'd0, 8'h00, "R11 random idle");
            end
        end

        summary();
        $finish;
    end
endmodule